// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block decides, cycle by cycle, whether the fetch stage of a three-stage in-order integer pipeline may hand its instruction on to execute. The stages are fetch (which also decodes and reads the register file and immediate), execute (which computes), and memory (which touches data memory and I/O and then commits the register write). Register results land in the register file only at the end of the memory stage. No operand path runs from the memory stage back into execute. The one bypass that remains carries the execute-stage result into the fetch-stage operand read. This lets the memory address and store data be formed before execute begins.

The controller keeps its own record of the destination, write flag and load flag of the instructions in execute and memory. It compares each source register that the fetched instruction really uses against that record, in fetch. From this it drives a hold for fetch and the program counter, a bubble into execute, and a per-operand select that picks the execute result over the register file. A taken branch or jump resolved in execute flushes the fetched instruction, and this flush overrides any hold. The controller has no input for the fetch source, so fetch from the boot memory and fetch from the instruction memory are handled the same way.

Top module: `tri_hazard_ctrl`

## Requirements
- R1: When a used, nonzero fetch source matches the destination of a writing non-load instruction in execute, that operand's forward select is 1 (take the execute result) and no hold is raised for it.
- R2: When a used, nonzero fetch source matches the destination of a writing load in execute, hold_o and bubble_o are 1, and while a load is in execute every forward select is 0.
- R3: When a used, nonzero fetch source matches a writing instruction in the memory stage and no writer in execute targets the same register, hold_o and bubble_o are 1. There is no memory-to-execute bypass.
- R4: Register 0 never causes a hold or a forward, whether it appears as a source or as a destination.
- R5: A source field whose use bit is 0 never causes a hold or a forward.
- R6: While hold_o is 1, bubble_o is 1 and the instruction that enters execute carries no valid write. The fetched instruction and the program counter stay where they are.
- R7: When x_redirect_i is 1, flush_o and bubble_o are 1 and hold_o is 0, even if a hazard is pending. The next execute entry is a bubble.
- R8: A consumer placed directly after its producer costs 0 hold cycles if the producer is a non-load and 2 if it is a load. Placed one instruction later, it costs 1 hold cycle for either kind.
- R9: After reset, both tracked stages are empty, so no fetch pattern raises a hold or a forward.
- R10: A cycle with f_valid_i at 0 sends a bubble into execute and raises no hold. Running any program through a pipeline steered by this controller leaves the same register values as a sequential, unpipelined run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| f_valid_i | input | 1 | Fetch stage holds a real instruction |
| f_src_i | input | NUM_SRC*5 | Source register numbers, slot k at bits [5k+4:5k] |
| f_src_use_i | input | NUM_SRC | Bit k set when source slot k is read |
| f_rd_i | input | 5 | Destination register of the fetched instruction |
| f_wen_i | input | 1 | Fetched instruction writes a register |
| f_load_i | input | 1 | Fetched instruction is a load |
| x_redirect_i | input | 1 | Taken branch or jump resolved in execute |
| hold_o | output | 1 | Freeze fetch and the program counter |
| bubble_o | output | 1 | Put an empty slot into execute |
| flush_o | output | 1 | Discard the fetched instruction because of a redirect |
| fwd_ex_o | output | NUM_SRC | Bit k: take the execute result for source slot k |

## Verification
The hardest case to reach is a fetched instruction that waits on a load sitting in the memory stage at the very cycle when execute holds a taken branch. The flush must win, and the refetched target must then read a register file that has just been written. Directed programs put a load, then a taken branch on an odd-valued register, then a consumer of the load in a row. Seeded random programs over four registers produce many more overlaps of load, memory-stage and redirect conditions. Each run is compared with an unpipelined model for final register contents and with per-cycle expected hold, flush and forward values.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  parameter int unsigned REG_AW = 5;

  // bookkeeping for one in-flight pipeline slot
  typedef struct packed {
    logic              valid;
    logic              wen;
    logic              load;
    logic [REG_AW-1:0] rd;
  } stage_t;

  localparam stage_t EMPTY_SLOT = '0;
endpackage

// File: rtl/hz_rst_sync.sv
`timescale 1ns/1ps
module hz_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/hz_stage_pipe.sv
`timescale 1ns/1ps
module hz_stage_pipe
  import hz_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  stage_t x_d,
  output stage_t x_q,
  output stage_t m_q
);
  logic adv_en;

  // the shadow slots advance every cycle; a hold shows up as an empty x_d
  assign adv_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= EMPTY_SLOT;
      m_q <= EMPTY_SLOT;
    end else if (adv_en) begin
      x_q <= x_d;
      m_q <= x_q;
    end
  end
endmodule

// File: rtl/hz_src_check.sv
`timescale 1ns/1ps
module hz_src_check
  import hz_pkg::*;
(
  input  logic [REG_AW-1:0] src,
  input  logic              used,
  input  stage_t            x_st,
  input  stage_t            m_st,
  output logic              need_hold,
  output logic              fwd_ex
);
  logic live;
  logic x_hit;
  logic m_hit;

  always_comb begin
    live  = used && (src != '0);
    x_hit = live && x_st.valid && x_st.wen && (x_st.rd == src);
    m_hit = live && m_st.valid && m_st.wen && (m_st.rd == src);
    // the newer writer in execute shadows an older one in memory
    fwd_ex    = x_hit && !x_st.load;
    need_hold = (x_hit && x_st.load) || (m_hit && !x_hit);
  end
endmodule

// File: rtl/tri_hazard_ctrl.sv
`timescale 1ns/1ps
module tri_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2,
  localparam int unsigned SRC_W  = NUM_SRC * REG_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               f_valid_i,
  input  logic [SRC_W-1:0]   f_src_i,
  input  logic [NUM_SRC-1:0] f_src_use_i,
  input  logic [REG_AW-1:0]  f_rd_i,
  input  logic               f_wen_i,
  input  logic               f_load_i,
  input  logic               x_redirect_i,
  output logic               hold_o,
  output logic               bubble_o,
  output logic               flush_o,
  output logic [NUM_SRC-1:0] fwd_ex_o
);
  logic               rst_q_n;
  stage_t             x_st;
  stage_t             m_st;
  stage_t             x_nxt;
  logic [NUM_SRC-1:0] src_hold;

  hz_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    hz_src_check u_chk (
      .src       (f_src_i[k*REG_AW +: REG_AW]),
      .used      (f_src_use_i[k]),
      .x_st      (x_st),
      .m_st      (m_st),
      .need_hold (src_hold[k]),
      .fwd_ex    (fwd_ex_o[k])
    );
  end

  always_comb begin
    flush_o  = x_redirect_i;
    hold_o   = f_valid_i && (|src_hold) && !x_redirect_i;
    bubble_o = hold_o || flush_o;
    if (bubble_o || !f_valid_i) begin
      x_nxt = EMPTY_SLOT;
    end else begin
      x_nxt.valid = 1'b1;
      x_nxt.wen   = f_wen_i;
      x_nxt.load  = f_load_i;
      x_nxt.rd    = f_rd_i;
    end
  end

  hz_stage_pipe u_pipe (
    .clk   (clk),
    .rst_n (rst_q_n),
    .x_d   (x_nxt),
    .x_q   (x_st),
    .m_q   (m_st)
  );
endmodule

// File: rtl/hz_ctrl_chk.sv
`timescale 1ns/1ps
module hz_ctrl_chk
  import hz_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic                      f_valid_i,
  input logic [NUM_SRC*REG_AW-1:0] f_src_i,
  input logic [NUM_SRC-1:0]        f_src_use_i,
  input logic                      x_redirect_i,
  input logic                      hold_o,
  input logic                      bubble_o,
  input logic                      flush_o,
  input logic [NUM_SRC-1:0]        fwd_ex_o,
  input stage_t                    x_st
);
  // R2
  no_load_fwd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (x_st.valid && x_st.load) |-> (fwd_ex_o == '0));
  // R4
  zero_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (f_src_i == '0) |-> (!hold_o && fwd_ex_o == '0));
  // R5
  unused_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (f_src_use_i == '0) |-> (!hold_o && fwd_ex_o == '0));
  // R6
  hold_bubble_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_o |-> bubble_o);
  // R6
  hold_empties_x_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_o |=> !x_st.valid);
  // R7
  flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    x_redirect_i |-> (flush_o && bubble_o && !hold_o));
  // R7
  flush_empties_x_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    x_redirect_i |=> !x_st.valid);
  // R10
  idle_fetch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !f_valid_i |=> !x_st.valid);
endmodule

bind tri_hazard_ctrl hz_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_hz_ctrl_chk (
  .clk          (clk),
  .rst_sync_n   (rst_q_n),
  .f_valid_i    (f_valid_i),
  .f_src_i      (f_src_i),
  .f_src_use_i  (f_src_use_i),
  .x_redirect_i (x_redirect_i),
  .hold_o       (hold_o),
  .bubble_o     (bubble_o),
  .flush_o      (flush_o),
  .fwd_ex_o     (fwd_ex_o),
  .x_st         (x_st)
);

// File: tb/test_tri_hazard_ctrl.sv
`timescale 1ns/1ps
module test_tri_hazard_ctrl;
  localparam int OP_ALU = 0, OP_ALUI = 1, OP_LD = 2, OP_BR = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic f_valid_i, f_wen_i, f_load_i, x_redirect_i;
  logic [9:0] f_src_i;
  logic [1:0] f_src_use_i;
  logic [4:0] f_rd_i;
  logic hold_o, bubble_o, flush_o;
  logic [1:0] fwd_ex_o;

  always #2.5 clk = ~clk;

  tri_hazard_ctrl i_tri_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .f_valid_i(f_valid_i), .f_src_i(f_src_i),
    .f_src_use_i(f_src_use_i), .f_rd_i(f_rd_i), .f_wen_i(f_wen_i),
    .f_load_i(f_load_i), .x_redirect_i(x_redirect_i), .hold_o(hold_o),
    .bubble_o(bubble_o), .flush_o(flush_o), .fwd_ex_o(fwd_ex_o)
  );

  int n_run = 0, n_fail = 0;
  int p_op[64], p_rd[64], p_rs1[64], p_rs2[64], p_imm[64];
  int plen;
  logic [31:0] rf[32], ref_rf[32];
  int pc, x_pc, m_pc;
  bit x_v, m_v;
  logic [31:0] x_a, x_b, m_res;

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] res_of(int op, logic [31:0] a, logic [31:0] b, int imm);
    case (op)
      OP_ALU:  return a + (b << 1) + imm;
      OP_ALUI: return a + imm;
      OP_LD:   return ((a + imm) & 32'd15) * 7 + 3;
      default: return '0;
    endcase
  endfunction

  function automatic bit writes(int op);
    return op != OP_BR;
  endfunction

  task automatic put(int op, int rd, int rs1, int rs2, int imm);
    p_op[plen] = op; p_rd[plen] = rd; p_rs1[plen] = rs1;
    p_rs2[plen] = rs2; p_imm[plen] = imm;
    plen++;
  endtask

  task automatic ref_run();
    int p = 0;
    logic [31:0] a, b;
    for (int i = 0; i < 32; i++) ref_rf[i] = i * 11;
    while (p < plen) begin
      a = ref_rf[p_rs1[p]]; b = ref_rf[p_rs2[p]];
      if (p_op[p] == OP_BR) begin
        p = a[0] ? p + 2 : p + 1;
      end else begin
        if (p_rd[p] != 0) ref_rf[p_rd[p]] = res_of(p_op[p], a, b, p_imm[p]);
        p++;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; f_valid_i = 1'b0; x_redirect_i = 1'b0;
    f_src_i = '0; f_src_use_i = '0; f_rd_i = '0; f_wen_i = 1'b0; f_load_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: stages empty after reset, any fetch pattern is free
    f_valid_i = 1'b1; f_src_i = {5'd2, 5'd1}; f_src_use_i = 2'b11;
    #1;
    chk(hold_o == 1'b0 && fwd_ex_o == 2'b00, "R9 reset state", {hold_o, fwd_ex_o}, 0);
    f_valid_i = 1'b0; f_src_use_i = '0;
  endtask

  task automatic run_prog(string name, int exp_holds, int exp_flush);
    int holds = 0, flushes = 0, guard = 0;
    do_reset();
    ref_run();
    for (int i = 0; i < 32; i++) rf[i] = i * 11;
    pc = 0; x_v = 0; m_v = 0; x_pc = 0; m_pc = 0;
    while ((pc < plen || x_v || m_v) && guard < 2000) begin
      bit f_ok, redir, haz, e_hold;
      int op, s[2], xo, mo, xpc_old;
      bit u[2];
      bit [1:0] e_fwd;
      logic [31:0] xres, a, b;
      string tag;
      guard++;
      @(negedge clk);
      f_ok = pc < plen;
      op = f_ok ? p_op[pc] : OP_BR;
      s[0] = f_ok ? p_rs1[pc] : 0; s[1] = f_ok ? p_rs2[pc] : 0;
      u[0] = f_ok; u[1] = f_ok && op == OP_ALU;
      xo = p_op[x_pc]; mo = p_op[m_pc];
      xres = res_of(xo, x_a, x_b, p_imm[x_pc]);
      redir = x_v && xo == OP_BR && x_a[0];
      f_valid_i = f_ok;
      f_src_i = {5'(s[1]), 5'(s[0])};
      f_src_use_i = {u[1], u[0]};
      f_rd_i = f_ok ? 5'(p_rd[pc]) : '0;
      f_wen_i = f_ok && writes(op);
      f_load_i = f_ok && op == OP_LD;
      x_redirect_i = redir;
      #1;
      haz = 0; e_fwd = '0; tag = "R4/none";
      for (int k = 0; k < 2; k++) begin
        bit hx, hm;
        hx = u[k] && s[k] != 0 && x_v && writes(xo) && p_rd[x_pc] == s[k];
        hm = u[k] && s[k] != 0 && m_v && writes(mo) && p_rd[m_pc] == s[k];
        e_fwd[k] = hx && xo != OP_LD;
        if (hx && xo == OP_LD) begin haz = 1; tag = "R2 load in execute"; end
        if (hm && !hx) begin haz = 1; tag = "R3 memory-stage match"; end
      end
      e_hold = f_ok && !redir && haz;
      if (redir) tag = "R7 redirect priority";
      chk(hold_o == e_hold, {name, " hold ", tag}, hold_o, e_hold);
      chk(flush_o == redir, {name, " R7 flush"}, flush_o, redir);
      chk(bubble_o == (e_hold || redir), {name, " R6 bubble"}, bubble_o, e_hold || redir);
      chk(fwd_ex_o == e_fwd, {name, " R1 forward select"}, fwd_ex_o, e_fwd);
      a = fwd_ex_o[0] ? xres : rf[s[0]];
      b = fwd_ex_o[1] ? xres : rf[s[1]];
      holds += hold_o; flushes += flush_o;
      xpc_old = x_pc;
      @(posedge clk);
      if (m_v && writes(mo) && p_rd[m_pc] != 0) rf[p_rd[m_pc]] = m_res;
      m_v = x_v; m_pc = x_pc; m_res = xres;
      if (bubble_o || !f_ok) x_v = 0;
      else begin x_v = 1; x_pc = pc; x_a = a; x_b = b; end
      if (flush_o) pc = xpc_old + 2;
      else if (!hold_o && f_ok) pc++;
    end
    chk(guard < 2000, {name, " R10 program drains"}, guard, 0);
    begin
      int bad = -1;
      for (int i = 0; i < 32; i++) if (rf[i] !== ref_rf[i] && bad < 0) bad = i;
      chk(bad < 0, {name, " R10 registers vs sequential model"},
          bad < 0 ? 0 : int'(rf[bad]), bad < 0 ? 0 : int'(ref_rf[bad]));
    end
    if (exp_holds >= 0) chk(holds == exp_holds, {name, " R8 hold cycles"}, holds, exp_holds);
    if (exp_flush >= 0) chk(flushes == exp_flush, {name, " R7 flush cycles"}, flushes, exp_flush);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    // R1 / R8: non-load producer, distance 1
    plen = 0; put(OP_ALU, 1, 2, 3, 5); put(OP_ALU, 3, 1, 1, 2);
    run_prog("alu_d1", 0, 0);
    // R8: non-load producer, distance 2
    plen = 0; put(OP_ALU, 1, 2, 3, 5); put(OP_ALU, 5, 6, 6, 1); put(OP_ALU, 3, 1, 2, 0);
    run_prog("alu_d2", 1, 0);
    // R2 / R8: load, distance 1
    plen = 0; put(OP_LD, 1, 2, 0, 3); put(OP_ALU, 3, 1, 0, 1);
    run_prog("load_d1", 2, 0);
    // R8: load, distance 2
    plen = 0; put(OP_LD, 1, 2, 0, 3); put(OP_ALUI, 7, 4, 0, 1); put(OP_ALU, 3, 0, 1, 1);
    run_prog("load_d2", 1, 0);
    // R4: register 0 as destination and source
    plen = 0; put(OP_ALU, 0, 2, 3, 9); put(OP_ALU, 4, 0, 0, 1); put(OP_LD, 0, 1, 0, 2);
    put(OP_ALU, 5, 0, 0, 2);
    run_prog("zero_reg", 0, 0);
    // R5: unused second source names the fresh destination
    plen = 0; put(OP_ALUI, 1, 2, 0, 4); put(OP_ALUI, 3, 2, 1, 1); put(OP_LD, 4, 2, 0, 1);
    put(OP_ALUI, 5, 6, 4, 0);
    run_prog("unused_src", 0, 0);
    // R7: taken branch in execute while a load in memory would stall fetch
    plen = 0; put(OP_LD, 2, 3, 0, 1); put(OP_BR, 0, 1, 0, 0); put(OP_ALU, 5, 2, 2, 0);
    put(OP_ALUI, 6, 2, 0, 1);
    run_prog("flush_over_hold", 0, 1);
    // R10: idle fetch gaps and a not-taken branch
    plen = 0; put(OP_BR, 0, 2, 0, 0); put(OP_ALU, 2, 2, 2, 1);
    run_prog("branch_not_taken", 0, 0);
    // random mixes over a small register set
    for (int r = 0; r < 8; r++) begin
      plen = 0;
      for (int i = 0; i < 40; i++) begin
        int sel = $urandom_range(0, 9);
        int op = sel < 4 ? OP_ALU : sel < 6 ? OP_ALUI : sel < 9 ? OP_LD : OP_BR;
        put(op, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 15));
      end
      run_prog($sformatf("rand%0d", r), -1, -1);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule